// File: doc/BRIEF.md
# CAS-Latency Data Slot Scheduler

This block is a synthesizable stand-in for the data side of an SDRAM device, meant to sit opposite a memory controller in a test harness. Each read or write command reserves four consecutive entries in a 16-entry circular schedule. The first reserved entry is the one the running pointer reaches a CAS-latency number of cycles later. The pointer moves forward one entry on every clock. As an entry becomes current it is serviced and then freed. A write entry stores the controller's data word into a small internal RAM. A read entry presents the word that was fetched from that RAM when the command was booked.

The burst base address is formed from three parts: the row that is open in the addressed bank (supplied by an external bank tracker as one flat vector), the bank number, and the column with its two lowest bits forced to zero. The four beats use the base address and the three addresses after it. The block also watches the bus direction during write beats and raises an error flag when the controller is not driving. The same flag is raised when a beat's address falls outside the internal RAM.

Top module: `cl_slot_sched`

## Requirements
- R1: The schedule pointer advances one entry per clock and wraps modulo SLOTS. A command in cycle t shows no beat in cycle t+CAS_LAT-1 or in cycle t+CAS_LAT+4, and the block keeps working after the pointer has wrapped many times.
- R2: A read command in cycle t with `cmd_op`=2'b01 presents memory word base+i on `rd_data` in cycle t+CAS_LAT+i for i=0..3, while `bus_oe` is low.
- R3: The burst base is {open_rows[bank*ROW_W +: ROW_W], bank, col[COL_W-1:2], 2'b00}, so the two low column bits have no effect.
- R4: A write command in cycle t with `cmd_op`=2'b10 stores the `wr_data` value present in cycle t+CAS_LAT+i at address base+i, for i=0..3.
- R5: A write beat whose `wr_mask` is high leaves the addressed memory word unchanged.
- R6: Read data is fetched from memory in the cycle the read is booked. A write burst that commits between the booking and the read's beats does not change the returned words.
- R7: While `bus_oe` is high, `rd_data` equals `wr_data`. While `bus_oe` is low and no beat is current, `rd_data` is zero.
- R8: `dir_err` is high in a write-beat cycle with `bus_oe` low, and the beat is still committed. `dir_err` stays low on in-range read beats and on in-range write beats with `bus_oe` high.
- R9: A beat whose address is at or above 2**MEM_AW raises `dir_err`, and a write beat at such an address does not modify any memory word.
- R10: `cmd_op` values 2'b00 and 2'b11 book nothing. The cycles CAS_LAT to CAS_LAT+3 after such a command show zero `rd_data` and low `dir_err`.
- R11: After reset every entry is free, `rd_data` is zero with `bus_oe` low, and `dir_err` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 2 | Command: 01 read, 10 write, others idle |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| cmd_col | input | COL_W | Column addressed by the command |
| open_rows | input | 2**BANK_W * ROW_W | Open row per bank, bank b at bits b*ROW_W upward |
| wr_data | input | DATA_W | Controller write data for the current beat |
| wr_mask | input | 1 | Suppresses storing the current write beat |
| bus_oe | input | 1 | Controller is driving the data bus |
| rd_data | output | DATA_W | Returned data word |
| dir_err | output | 1 | Direction or address-range error on the current beat |

## Verification
The bench places a write and a read four cycles apart so that the write commits after the read has fetched but before the read's beats appear. A design that reads memory at service time instead of at booking time would return the new words there. Each read is sampled one cycle before and one cycle after its burst window, which exposes an off-by-one latency or a pointer that fails to free entries. Masked beats, write beats with the bus not driven, and a bank whose address lands past the RAM are each checked. A design that drops the mask would corrupt a word. A design that truncates an out-of-range address before checking it would overwrite word zero without raising the flag.

// File: rtl/cls_pkg.sv
`timescale 1ns/1ps
package cls_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'b00,
      OP_READ  = 2'b01,
      OP_WRITE = 2'b10,
      OP_SPARE = 2'b11
   } cls_op_e;
endpackage

// File: rtl/cls_addr_gen.sv
`timescale 1ns/1ps
module cls_addr_gen #(
   parameter int ROW_W  = 14,
   parameter int BANK_W = 3,
   parameter int COL_W  = 8,
   parameter int BURST  = 4
) (
   input  logic [BANK_W-1:0]                             bank,
   input  logic [COL_W-1:0]                              col,
   input  logic [(1<<BANK_W)*ROW_W-1:0]                  open_rows,
   output logic [BURST-1:0][ROW_W+BANK_W+COL_W-1:0]      beat_addr
);
   localparam int ADDR_W = ROW_W + BANK_W + COL_W;
   localparam int LOW_W  = $clog2(BURST);

   logic [ROW_W-1:0]  row_sel;
   logic [ADDR_W-1:0] base;

   always_comb begin
      row_sel = open_rows[bank*ROW_W +: ROW_W];
      base    = {row_sel, bank, col[COL_W-1:LOW_W], {LOW_W{1'b0}}};
   end

   // low bits of base are zero, so each beat just fills them in
   for (genvar b = 0; b < BURST; b++) begin : g_beat
      assign beat_addr[b] = base | ADDR_W'(b);
   end
endmodule

// File: rtl/cls_word_ram.sv
`timescale 1ns/1ps
module cls_word_ram #(
   parameter int DATA_W = 32,
   parameter int AW     = 10,
   parameter int NRD    = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [AW-1:0]                 waddr,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [NRD-1:0][AW-1:0]        raddr,
   output logic [NRD-1:0][DATA_W-1:0]    rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk)
      if (we) mem[waddr] <= wdata;

   for (genvar i = 0; i < NRD; i++) begin : g_rport
      assign rdata[i] = mem[raddr[i]];
   end

   // R4: a committed beat is visible at its address on the next cycle
   p_ram_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/cls_slot_ring.sv
`timescale 1ns/1ps
module cls_slot_ring #(
   parameter int SLOTS   = 16,
   parameter int CAS_LAT = 5,
   parameter int BURST   = 4,
   parameter int ADDR_W  = 25,
   parameter int DATA_W  = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            book,
   input  logic                            book_rd,
   input  logic [BURST-1:0][ADDR_W-1:0]    book_addr,
   input  logic [BURST-1:0][DATA_W-1:0]    book_data,
   output logic                            cur_used,
   output logic                            cur_rd,
   output logic [ADDR_W-1:0]               cur_addr,
   output logic [DATA_W-1:0]               cur_data
);
   localparam int PW = $clog2(SLOTS);

   logic [PW-1:0]     ptr_q;
   logic [SLOTS-1:0]  used_q;
   logic [SLOTS-1:0]  rd_q;
   logic [ADDR_W-1:0] addr_q [SLOTS];
   logic [DATA_W-1:0] data_q [SLOTS];

   function automatic logic [PW-1:0] slot_of(input logic [PW-1:0] p, input int ofs);
      return p + PW'(ofs);
   endfunction

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ptr_q  <= '0;
         used_q <= '0;
         rd_q   <= '0;
         for (int s = 0; s < SLOTS; s++) begin
            addr_q[s] <= '1;
            data_q[s] <= '0;
         end
      end else begin
         ptr_q <= ptr_q + PW'(1);
         // retire the entry serviced this cycle
         used_q[ptr_q] <= 1'b0;
         rd_q[ptr_q]   <= 1'b0;
         addr_q[ptr_q] <= '1;
         data_q[ptr_q] <= '0;
         if (book) begin
            for (int b = 0; b < BURST; b++) begin
               used_q[slot_of(ptr_q, CAS_LAT + b)] <= 1'b1;
               rd_q[slot_of(ptr_q, CAS_LAT + b)]   <= book_rd;
               addr_q[slot_of(ptr_q, CAS_LAT + b)] <= book_addr[b];
               data_q[slot_of(ptr_q, CAS_LAT + b)] <= book_rd ? book_data[b] : '0;
            end
         end
      end

   assign cur_used = used_q[ptr_q];
   assign cur_rd   = rd_q[ptr_q];
   assign cur_addr = addr_q[ptr_q];
   assign cur_data = data_q[ptr_q];

   // R1: the entry just serviced is free one cycle later
   p_slot_freed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cur_used |=> !used_q[slot_of(ptr_q, SLOTS - 1)]);

   // R2: a booking reserves the entry CAS_LAT ahead with its direction
   p_book_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      book |=> used_q[slot_of(ptr_q, CAS_LAT - 1)]
               && (rd_q[slot_of(ptr_q, CAS_LAT - 1)] == $past(book_rd)));

   // R3: the first reserved entry carries the burst base address
   p_book_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      book |=> addr_q[slot_of(ptr_q, CAS_LAT - 1)] == $past(book_addr[0]));
endmodule

// File: rtl/cl_slot_sched.sv
`timescale 1ns/1ps
module cl_slot_sched #(
   parameter int DATA_W  = 32,
   parameter int ROW_W   = 14,
   parameter int BANK_W  = 3,
   parameter int COL_W   = 8,
   parameter int MEM_AW  = 10,
   parameter int SLOTS   = 16,
   parameter int CAS_LAT = 5,
   parameter int BURST   = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [1:0]                        cmd_op,
   input  logic [BANK_W-1:0]                 cmd_bank,
   input  logic [COL_W-1:0]                  cmd_col,
   input  logic [(1<<BANK_W)*ROW_W-1:0]      open_rows,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic                              wr_mask,
   input  logic                              bus_oe,
   output logic [DATA_W-1:0]                 rd_data,
   output logic                              dir_err
);
   import cls_pkg::*;

   localparam int ADDR_W = ROW_W + BANK_W + COL_W;

   if ((1 << $clog2(SLOTS)) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two");
   end
   if (CAS_LAT + BURST > SLOTS) begin : g_bad_lat
      $error("CAS_LAT + BURST must not exceed SLOTS");
   end
   if ((1 << $clog2(BURST)) != BURST || COL_W < $clog2(BURST)) begin : g_bad_burst
      $error("BURST must be a power of two that fits in the column");
   end
   if (MEM_AW > ADDR_W) begin : g_bad_mem
      $error("MEM_AW must not exceed the full address width");
   end

   cls_op_e op;
   logic    book, book_rd;

   always_comb begin
      op      = cls_op_e'(cmd_op);
      book    = (op == OP_READ) || (op == OP_WRITE);
      book_rd = (op == OP_READ);
   end

   logic [BURST-1:0][ADDR_W-1:0] beat_addr;
   logic [BURST-1:0][MEM_AW-1:0] fetch_addr;
   logic [BURST-1:0][DATA_W-1:0] fetch_data;

   cls_addr_gen #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .BURST(BURST)) u_addr (
      .bank      (cmd_bank),
      .col       (cmd_col),
      .open_rows (open_rows),
      .beat_addr (beat_addr)
   );

   for (genvar b = 0; b < BURST; b++) begin : g_trunc
      assign fetch_addr[b] = beat_addr[b][MEM_AW-1:0];
   end

   logic              cur_used, cur_rd, cur_oor, ram_we;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_data;

   cls_slot_ring #(.SLOTS(SLOTS), .CAS_LAT(CAS_LAT), .BURST(BURST),
                   .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .book      (book),
      .book_rd   (book_rd),
      .book_addr (beat_addr),
      .book_data (fetch_data),
      .cur_used  (cur_used),
      .cur_rd    (cur_rd),
      .cur_addr  (cur_addr),
      .cur_data  (cur_data)
   );

   if (ADDR_W > MEM_AW) begin : g_range
      assign cur_oor = |cur_addr[ADDR_W-1:MEM_AW];
   end else begin : g_norange
      assign cur_oor = 1'b0;
   end

   assign ram_we = cur_used && !cur_rd && !wr_mask && !cur_oor;

   cls_word_ram #(.DATA_W(DATA_W), .AW(MEM_AW), .NRD(BURST)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ram_we),
      .waddr (cur_addr[MEM_AW-1:0]),
      .wdata (wr_data),
      .raddr (fetch_addr),
      .rdata (fetch_data)
   );

   assign dir_err = cur_used && ((!cur_rd && !bus_oe) || cur_oor);
   assign rd_data = bus_oe ? wr_data : cur_data;

   // R8: an in-range read beat never reports a direction error
   p_read_beat_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_used && cur_rd && !cur_oor) |-> !dir_err);
endmodule

// File: tb/cl_slot_sched_tb.sv
`timescale 1ns/1ps
module cl_slot_sched_tb;
   localparam int DATA_W = 32, ROW_W = 14, BANK_W = 3, COL_W = 8, MEM_AW = 10;
   localparam int CL = 5;

   logic                         clk = 1'b0;
   logic                         rst_n = 1'b0;
   logic [1:0]                   cmd_op = 2'b00;
   logic [BANK_W-1:0]            cmd_bank = '0;
   logic [COL_W-1:0]             cmd_col = '0;
   logic [(1<<BANK_W)*ROW_W-1:0] open_rows = '0;
   logic [DATA_W-1:0]            wr_data = '0;
   logic                         wr_mask = 1'b0;
   logic                         bus_oe = 1'b0;
   logic [DATA_W-1:0]            rd_data;
   logic                         dir_err;

   int n_chk = 0, n_bad = 0;
   logic [DATA_W-1:0] ref_mem [1<<MEM_AW];

   always #4 clk = ~clk;

   cl_slot_sched u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
      .cmd_col(cmd_col), .open_rows(open_rows), .wr_data(wr_data),
      .wr_mask(wr_mask), .bus_oe(bus_oe), .rd_data(rd_data), .dir_err(dir_err)
   );

   task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle: drive at the falling edge, return just before the rising edge
   task automatic cyc(input logic [1:0] op, input int bank, input int col,
                      input logic [DATA_W-1:0] wd, input logic m, input logic oe);
      @(negedge clk);
      cmd_op = op; cmd_bank = BANK_W'(bank); cmd_col = COL_W'(col);
      wr_data = wd; wr_mask = m; bus_oe = oe;
      #3;
   endtask

   function automatic int base_of(input int bank, input int col);
      return (bank << COL_W) | (col & ~3);
   endfunction

   task automatic do_write(input int bank, input int col, input logic [3:0][DATA_W-1:0] d,
                           input logic [3:0] m, input logic [3:0] oe);
      int base = base_of(bank, col);
      bit oor  = base >= (1 << MEM_AW);
      cyc(2'b10, bank, col, '0, 1'b0, 1'b0);
      for (int k = 1; k < CL; k++) cyc(2'b00, 0, 0, '0, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) begin
         cyc(2'b00, 0, 0, d[i], m[i], oe[i]);
         if (oe[i]) chk("R7 echo", rd_data, d[i]);
         chk(oor ? "R9 range flag" : "R8 direction flag", {31'd0, dir_err},
             {31'd0, oor || !oe[i]});
         if (!m[i] && !oor) ref_mem[(base + i) % (1 << MEM_AW)] = d[i];
      end
   endtask

   task automatic do_read(input int bank, input int col);
      int base = base_of(bank, col);
      bit oor  = base >= (1 << MEM_AW);
      cyc(2'b01, bank, col, '0, 1'b0, 1'b0);
      for (int k = 1; k < CL; k++) cyc(2'b00, 0, 0, '0, 1'b0, 1'b0);
      chk("R1 no early beat", rd_data, '0);
      for (int i = 0; i < 4; i++) begin
         cyc(2'b00, 0, 0, '0, 1'b0, 1'b0);
         chk("R2 read beat", rd_data, ref_mem[(base + i) % (1 << MEM_AW)]);
         chk(oor ? "R9 read range flag" : "R8 read no flag", {31'd0, dir_err}, {31'd0, oor});
      end
      cyc(2'b00, 0, 0, '0, 1'b0, 1'b0);
      chk("R1 no late beat", rd_data, '0);
   endtask

   task automatic t_reset();
      cyc(2'b00, 0, 0, '0, 1'b0, 1'b0);
      chk("R11 reset data", rd_data, '0);
      chk("R11 reset flag", {31'd0, dir_err}, '0);
   endtask

   task automatic t_basic();
      do_write(0, 0, {32'hA3, 32'hA2, 32'hA1, 32'hA0}, 4'b0000, 4'b1111);
      do_read(0, 0);
      do_write(0, 8, {32'hB3, 32'hB2, 32'hB1, 32'hB0}, 4'b0000, 4'b1111);
      do_read(0, 8);
   endtask

   task automatic t_mask();
      do_write(0, 8, {32'hC3, 32'hC2, 32'hC1, 32'hC0}, 4'b0010, 4'b1111); // R5
      do_read(0, 8);
   endtask

   task automatic t_layout();
      do_write(2, 8'h13, {32'hD3, 32'hD2, 32'hD1, 32'hD0}, 4'b0000, 4'b1111); // R3
      do_write(1, 8'h10, {32'hE3, 32'hE2, 32'hE1, 32'hE0}, 4'b0000, 4'b1111);
      do_read(2, 8'h10);
      do_read(1, 8'h12);
   endtask

   task automatic t_fetch_time();
      logic [3:0][DATA_W-1:0] nd = {32'hF3, 32'hF2, 32'hF1, 32'hF0};
      logic [3:0][DATA_W-1:0] old;
      for (int i = 0; i < 4; i++) old[i] = ref_mem[i];
      cyc(2'b10, 0, 0, '0, 1'b0, 1'b0);
      for (int k = 1; k < 4; k++) cyc(2'b00, 0, 0, '0, 1'b0, 1'b0);
      cyc(2'b01, 0, 0, '0, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) cyc(2'b00, 0, 0, nd[i], 1'b0, 1'b1);
      for (int i = 0; i < 4; i++) begin
         cyc(2'b00, 0, 0, '0, 1'b0, 1'b0);
         chk("R6 data fetched at booking", rd_data, old[i]);
      end
      for (int i = 0; i < 4; i++) ref_mem[i] = nd[i];
      do_read(0, 0);
   endtask

   task automatic t_direction();
      do_write(0, 4, {32'h53, 32'h52, 32'h51, 32'h50}, 4'b0000, 4'b1011); // R8
      do_read(0, 4);
   endtask

   task automatic t_range();
      do_write(4, 0, {32'h93, 32'h92, 32'h91, 32'h90}, 4'b0000, 4'b1111); // R9
      do_read(0, 0);
      do_read(4, 0);
   endtask

   task automatic t_idle_codes();
      for (int c = 0; c < 2; c++) begin
         cyc(c == 0 ? 2'b11 : 2'b00, 0, 0, '0, 1'b0, 1'b0);
         for (int k = 1; k < CL + 4; k++) begin
            cyc(2'b00, 0, 0, '0, 1'b0, 1'b0);
            if (k >= CL) begin
               chk("R10 no booking data", rd_data, '0);
               chk("R10 no booking flag", {31'd0, dir_err}, '0);
            end
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < (1 << MEM_AW); i++) ref_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_mask();
      t_layout();
      t_fetch_time();
      t_direction();
      t_range();
      t_idle_codes();
      repeat (20) t_basic(); // pointer wraps many times (R1)
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule